// File: doc/BRIEF.md
# Shared-Pin Eight-Bit I/O Port Controller

The block controls eight bidirectional pins. Each pin can serve as a general-purpose I/O or be lent to an on-chip peripheral: the asynchronous serial interface on bits 1:0, the SPI on bits 5:2, and the external-bus strobes on bits 7:6 when the chip runs in expanded mode. Software reaches two registers over a simple register bus. The output-latch register sits at offset 0x08 and the direction register at offset 0x09. For every pin the block decides three things: whether the pad driver is enabled, what value it drives, and what a read of the latch register returns.

Mode inputs select who owns each pin. An enabled SPI claims its input pins whatever the direction bits say. The SPI's output pins still need their direction bit set before they drive. The slave-select pin's direction bit has one meaning in master mode and none in slave mode. Before any pin level reaches software or a peripheral, it passes through a two-stage synchronizer.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset both registers read 0x00, every pin_oe bit is 0 and every pin_out bit is 0.
- R2: A write with bus_sel and bus_wr high takes effect at the next rising clock edge. Offset 0x08 writes the output latch and offset 0x09 writes the direction register. The direction register reads back unchanged. Any other offset reads 0x00, and a write to it changes neither register.
- R3: For a pin in GPIO use, direction bit 1 gives pin_oe=1 with pin_out equal to the latch bit. Direction bit 0 gives pin_oe=0. The latch is written whatever the direction, and pin_out is 0 whenever pin_oe is 0.
- R4: A read of offset 0x08 returns, per bit, pin_out where pin_oe is 1 and the synchronized pin level where pin_oe is 0.
- R5: A pin_in change appears in synchronized form after exactly two rising clock edges. It is not yet visible after one edge.
- R6: With mode_expanded=1, bit 7 drives bus_rw and bit 6 drives bus_as with pin_oe=1, whatever their direction bits.
- R7: With spi_en=1 and spi_master=1, bit 2 (MISO) is an input whatever its direction bit. Bits 3 (MOSI) and 4 (SCK) drive spi_mosi_o and spi_sck_o only while their direction bit is 1; otherwise they float.
- R8: With spi_en=1 and spi_master=0, bits 3, 4 and 5 are inputs whatever their direction bits. Bit 2 drives spi_miso_o only while its direction bit is 1 and the synchronized bit 5 is low (slave selected).
- R9: With spi_en=1 and spi_master=1, direction bit 5 at 0 makes bit 5 an input whose synchronized level feeds spi_ss_n. At 1, bit 5 is a GPIO output from the latch and spi_ss_n is 1. spi_ss_n is also 1 when the SPI is disabled.
- R10: With sci_en=1, bit 0 is an input whose synchronized level feeds sci_rxd, and bit 1 drives sci_txd with pin_oe=1. With sci_en=0 both bits are GPIO and sci_rxd is 1.
- R11: spi_miso_i, spi_mosi_i and spi_sck_i always equal the synchronized levels of bits 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| mode_expanded | input | 1 | Expanded/test bus mode |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI master (1) or slave (0) |
| sci_en | input | 1 | Serial interface enabled |
| sci_txd | input | 1 | Serial transmit data |
| spi_mosi_o | input | 1 | SPI master-out data |
| spi_miso_o | input | 1 | SPI slave-out data |
| spi_sck_o | input | 1 | SPI clock output (master) |
| bus_rw | input | 1 | Bus read/write strobe |
| bus_as | input | 1 | Bus address strobe |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output enables |
| sci_rxd | output | 1 | Synchronized receive data |
| spi_miso_i | output | 1 | Synchronized bit 2 |
| spi_mosi_i | output | 1 | Synchronized bit 3 |
| spi_sck_i | output | 1 | Synchronized bit 4 |
| spi_ss_n | output | 1 | Slave select / mode-fault input to SPI |

## Verification
Every combination of the four mode inputs is swept against all 256 direction values. Each run uses its own latch contents, pin levels and peripheral drive values, so a pin that takes its value from the wrong source stands out. Because the pin levels vary, the slave-select level changes too, and that separates the gated MISO drive from the ungated one. Directed cases single out the forced-input rules, the dual meaning of direction bit 5, the one-versus-two-edge synchronizer latency and the ignored offsets.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 8;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
    } port_regs_t;

    typedef enum logic [1:0] {
        USE_GPIO  = 2'd0,
        USE_INPUT = 2'd1,
        USE_DRIVE = 2'd2,
        USE_FLOAT = 2'd3
    } pin_use_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_OFFS  = 8,
    parameter int DIR_OFFS   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] rd_level,
    output logic [PORT_W-1:0] rdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFFS);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_OFFS);

    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sel && wr && addr == A_DATA) regs_d.latch = wdata;
        if (sel && wr && addr == A_DIR)  regs_d.dir   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (addr == A_DATA)     rdata = rd_level;
        else if (addr == A_DIR) rdata = regs_q.dir;
        else                    rdata = '0;
    end

    assign latch_q = regs_q.latch;
    assign dir_q   = regs_q.dir;

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == A_DIR) |=> dir_q == $past(wdata));
    p_latch_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == A_DATA) |=> latch_q == $past(wdata));
    p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr && (addr == A_DATA || addr == A_DIR)) |=> $stable(dir_q) && $stable(latch_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] age_d, age_q;
            always_comb age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) age_q <= '0;
                else        age_q <= age_d;
            end
            p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd2) |-> sync_out == $past(async_in, 2));
        end
    endgenerate
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] latch,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] pin_s,
    input  logic              mode_expanded,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              sci_en,
    input  logic [PORT_W-1:0] periph_val,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] drv,
    output logic              ss_n,
    output logic              rxd
);
    pin_use_e use_sel [PORT_W];
    logic     ss_active;

    assign ss_active = ~pin_s[5];

    always_comb begin
        use_sel[0] = sci_en ? USE_INPUT : USE_GPIO;
        use_sel[1] = sci_en ? USE_DRIVE : USE_GPIO;
        if (!spi_en)         use_sel[2] = USE_GPIO;
        else if (spi_master) use_sel[2] = USE_INPUT;
        else                 use_sel[2] = (dir[2] && ss_active) ? USE_DRIVE : USE_FLOAT;
        for (int b = 3; b <= 4; b++) begin
            if (!spi_en)         use_sel[b] = USE_GPIO;
            else if (spi_master) use_sel[b] = dir[b] ? USE_DRIVE : USE_FLOAT;
            else                 use_sel[b] = USE_INPUT;
        end
        if (!spi_en)          use_sel[5] = USE_GPIO;
        else if (!spi_master) use_sel[5] = USE_INPUT;
        else                  use_sel[5] = dir[5] ? USE_GPIO : USE_INPUT;
        use_sel[6] = mode_expanded ? USE_DRIVE : USE_GPIO;
        use_sel[7] = mode_expanded ? USE_DRIVE : USE_GPIO;
    end

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_pin
            always_comb begin
                unique case (use_sel[i])
                    USE_GPIO: begin
                        oe[i]  = dir[i];
                        drv[i] = dir[i] & latch[i];
                    end
                    USE_DRIVE: begin
                        oe[i]  = 1'b1;
                        drv[i] = periph_val[i];
                    end
                    default: begin
                        oe[i]  = 1'b0;
                        drv[i] = 1'b0;
                    end
                endcase
            end
        end
    endgenerate

    assign ss_n = (spi_en && use_sel[5] == USE_INPUT) ? pin_s[5] : 1'b1;
    assign rxd  = sci_en ? pin_s[0] : 1'b1;

    p_bus_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_expanded |-> oe[7:6] == 2'b11);
    p_master_miso_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> !oe[2]);
    p_slave_inputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> oe[5:3] == 3'b000);
    p_slave_unselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master && pin_s[5]) |-> !oe[2]);
    p_rx_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en |-> !oe[0] && oe[1]);
    p_quiet_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv & ~oe) == '0);
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_OFFS   = 8,
    parameter int DIR_OFFS    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              mode_expanded,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              sci_en,
    input  logic              sci_txd,
    input  logic              spi_mosi_o,
    input  logic              spi_miso_o,
    input  logic              spi_sck_o,
    input  logic              bus_rw,
    input  logic              bus_as,
    input  logic [7:0]        pin_in,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe,
    output logic              sci_rxd,
    output logic              spi_miso_i,
    output logic              spi_mosi_i,
    output logic              spi_sck_i,
    output logic              spi_ss_n
);
    logic [PORT_W-1:0] latch_q, dir_q, pin_s, rd_level, periph_val;

    assign periph_val = {bus_rw, bus_as, 1'b0, spi_sck_o, spi_mosi_o, spi_miso_o, sci_txd, 1'b0};

    gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_s)
    );

    gpio_regs #(.ADDR_W(ADDR_W), .DATA_OFFS(DATA_OFFS), .DIR_OFFS(DIR_OFFS)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rd_level(rd_level), .rdata(bus_rdata),
        .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_pin_mux u_mux (
        .clk(clk), .rst_n(rst_n), .latch(latch_q), .dir(dir_q), .pin_s(pin_s),
        .mode_expanded(mode_expanded), .spi_en(spi_en), .spi_master(spi_master),
        .sci_en(sci_en), .periph_val(periph_val), .oe(pin_oe), .drv(pin_out),
        .ss_n(spi_ss_n), .rxd(sci_rxd)
    );

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_rd
            assign rd_level[i] = pin_oe[i] ? pin_out[i] : pin_s[i];
        end
    endgenerate

    assign spi_miso_i = pin_s[2];
    assign spi_mosi_i = pin_s[3];
    assign spi_sck_i  = pin_s[4];

    p_spi_in_forward_r11: assert property (@(posedge clk) disable iff (!rst_n)
        {spi_sck_i, spi_mosi_i, spi_miso_i} == $past(pin_in[4:2], 2) || $past(!rst_n, 2));
endmodule

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic mode_expanded = 0, spi_en = 0, spi_master = 0, sci_en = 0;
    logic sci_txd = 0, spi_mosi_o = 0, spi_miso_o = 0, spi_sck_o = 0, bus_rw = 0, bus_as = 0;
    logic [7:0] pin_in = 0, pin_out, pin_oe;
    logic sci_rxd, spi_miso_i, spi_mosi_i, spi_sck_i, spi_ss_n;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_mux_port u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Reference built from the requirements; pin is the settled (synchronized) level.
    task automatic model(input logic [7:0] dir, latch, pin, input logic ex, sp, ms, sc,
                         input logic [7:0] pv, output logic [7:0] oe, out, rdv,
                         output logic ss, rx);
        for (int b = 0; b < 8; b++) begin
            oe[b] = dir[b]; out[b] = dir[b] & latch[b];
        end
        if (sc) begin oe[0] = 0; out[0] = 0; oe[1] = 1; out[1] = pv[1]; end
        ss = 1;
        if (sp) begin
            if (ms) begin
                oe[2] = 0; out[2] = 0;
                for (int b = 3; b <= 4; b++) begin oe[b] = dir[b]; out[b] = dir[b] & pv[b]; end
                if (!dir[5]) begin oe[5] = 0; out[5] = 0; ss = pin[5]; end
            end else begin
                oe[2] = dir[2] & ~pin[5]; out[2] = oe[2] & pv[2];
                for (int b = 3; b <= 5; b++) begin oe[b] = 0; out[b] = 0; end
                ss = pin[5];
            end
        end
        if (ex) begin oe[7] = 1; out[7] = pv[7]; oe[6] = 1; out[6] = pv[6]; end
        for (int b = 0; b < 8; b++) rdv[b] = oe[b] ? out[b] : pin[b];
        rx = sc ? pin[0] : 1'b1;
    endtask

    function automatic logic [7:0] pv_now();
        return {bus_rw, bus_as, 1'b0, spi_sck_o, spi_mosi_o, spi_miso_o, sci_txd, 1'b0};
    endfunction

    initial begin
        logic [7:0] r;
        logic [7:0] eoe, eout, erd;
        logic ess, erx;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(8'h08, r); check("R1 data read", r, 8'h00);
        rd(8'h09, r); check("R1 dir read", r, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        rst_n = 1;
        // R2 register access
        wr(8'h09, 8'hA5); rd(8'h09, r); check("R2 dir readback", r, 8'hA5);
        wr(8'h0A, 8'hFF); rd(8'h0A, r); check("R2 other offset reads 0", r, 8'h00);
        rd(8'h09, r); check("R2 stray write ignored (dir)", r, 8'hA5);
        check("R2 stray write ignored (latch via out)", pin_out, 8'h00);
        // R3 latch written while input, then driven
        wr(8'h09, 8'h00); wr(8'h08, 8'h3C);
        check("R3 dir0 no drive", pin_oe, 8'h00);
        wr(8'h09, 8'hFF);
        check("R3 oe", pin_oe, 8'hFF); check("R3 out", pin_out, 8'h3C);
        // R4 mixed read
        wr(8'h09, 8'h0F); wr(8'h08, 8'h05); pin_in = 8'hF0; settle();
        rd(8'h08, r); check("R4 mixed read", r, 8'hF5);
        // R5 latency
        wr(8'h09, 8'h00); pin_in = 8'h00; settle();
        pin_in = 8'hFF;
        @(negedge clk); rd(8'h08, r); check("R5 after one edge", r, 8'h00);
        @(negedge clk); rd(8'h08, r); check("R5 after two edges", r, 8'hFF);
        // R6 bus strobes
        wr(8'h09, 8'h00); mode_expanded = 1; bus_rw = 1; bus_as = 0; #1;
        check("R6 oe", pin_oe[7:6], 2'b11); check("R6 out", pin_out[7:6], 2'b10);
        mode_expanded = 0;
        // R7 master
        spi_en = 1; spi_master = 1; spi_mosi_o = 1; spi_sck_o = 1;
        wr(8'h09, 8'h04); check("R7 MISO forced input", pin_oe[2], 1'b0);
        check("R7 MOSI/SCK float", pin_oe[4:3], 2'b00);
        wr(8'h09, 8'h18); check("R7 MOSI/SCK drive", {pin_oe[4:3], pin_out[4:3]}, 4'b1111);
        // R9 master bit 5
        wr(8'h08, 8'h20); wr(8'h09, 8'h00); pin_in = 8'h00; settle();
        check("R9 fault input", {pin_oe[5], spi_ss_n}, 2'b00);
        pin_in = 8'h20; settle(); check("R9 fault input high", spi_ss_n, 1'b1);
        pin_in = 8'h00; wr(8'h09, 8'h20); settle();
        check("R9 GPIO output", {pin_oe[5], pin_out[5], spi_ss_n}, 3'b111);
        // R8 slave
        spi_master = 0; spi_miso_o = 1; wr(8'h09, 8'h3C); pin_in = 8'h00; settle();
        check("R8 selected MISO drive", {pin_oe[5:2], pin_out[2]}, 5'b00011);
        pin_in = 8'h20; settle();
        check("R8 unselected MISO float", pin_oe[5:2], 4'b0000);
        // R11 forwarding
        pin_in = 8'h1C; settle();
        check("R11 spi inputs", {spi_sck_i, spi_mosi_i, spi_miso_i}, 3'b111);
        spi_en = 0;
        // R10 serial interface
        sci_en = 1; sci_txd = 1; wr(8'h09, 8'h03); pin_in = 8'h01; settle();
        check("R10 rx/tx", {pin_oe[1:0], pin_out[1], sci_rxd}, 4'b1011);
        sci_en = 0; #1;
        check("R10 disabled GPIO", {pin_oe[1:0], sci_rxd}, 3'b111);
        // Sweep: R3 R4 R6 R7 R8 R9 R10 over all modes and direction values
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 256; d++) begin
                logic [7:0] dv, lv, pv;
                dv = 8'(d); lv = ~dv ^ 8'(m * 37);
                {mode_expanded, spi_en, spi_master, sci_en} = 4'(m);
                pv = 8'(d * 7 + m);
                {bus_rw, bus_as} = pv[7:6]; {spi_sck_o, spi_mosi_o, spi_miso_o, sci_txd} = pv[4:1];
                pin_in = dv ^ 8'hC3 ^ 8'(m);
                wr(8'h08, lv); wr(8'h09, dv); settle();
                model(dv, lv, pin_in, mode_expanded, spi_en, spi_master, sci_en, pv_now(),
                      eoe, eout, erd, ess, erx);
                rd(8'h08, r);
                check("R3/R6/R7/R8/R9/R10 sweep oe", pin_oe, eoe);
                check("R3/R6/R7/R8/R9/R10 sweep out", pin_out, eout);
                check("R4 sweep read", r, erd);
                check("R9/R10 sweep ss/rx", {spi_ss_n, sci_rxd}, {ess, erx});
            end
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule